// File: doc/BRIEF.md
# Sparse Input Row Skip Controller

This block sits beside the input side of a fully connected layer's crossbar. It decides which input rows carry so few non-zero weights that their row drivers can be turned off. Software starts a scan with the layer's row count, column count and a percentage code. The weight matrix then arrives one weight per cycle, in row-major order, with the row and column index of each weight. The block counts the zero weights in every row and turns that row off when its count is above a threshold. The threshold is the given percentage of the column count, rounded down.

The resulting enable mask gates the activation value presented to each row driver: a row that is off receives zero. The same mask is exported to the previous layer, so that the output converters producing the skipped neurons can be switched off. A count of eliminated rows is reported for cross-checking. The new mask and count take effect together when the final weight of the matrix arrives, and the previous mask stays in force while a scan runs. For convolutional layers the block is placed in bypass, and every row is enabled.

Top module: `row_skip_ctrl`

## Requirements
- R1: After reset every bit of `row_en` is 1, `skip_count` is 0, and `busy`, `cfg_err` and `seq_err` are 0.
- R2: A weight counts as zero when all bits of `w_data` are 0. The threshold is floor(pct × cols / 100), and row r is disabled (`row_en[r]`=0) exactly when its zero count is strictly greater than that threshold.
- R3: A start in fully connected mode is accepted only when `cfg_pct` is a multiple of 5 from 10 to 40, and both `cfg_rows` and `cfg_cols` are non-zero and no larger than their maxima. Otherwise `cfg_err` is 1 on the next cycle, no scan starts and `row_en` is unchanged.
- R4: `busy` is 1 from the cycle after an accepted start until the cycle after the beat for row rows-1, column cols-1. While `busy` is 1, `row_en` keeps its previous value.
- R5: On the edge that takes the final beat, `row_en` and `skip_count` update together. `skip_count` equals the number of cleared bits, and rows at or above `cfg_rows` stay enabled.
- R6: Beats must arrive with the column index running fastest from 0, then the row index from 0. A beat with any other index pair sets `seq_err`, aborts the scan (`busy` goes to 0) and leaves `row_en` unchanged.
- R7: A start with `cfg_fc`=0 (bypass) sets every bit of `row_en` to 1 and `skip_count` to 0 on the next cycle. It ignores the other configuration inputs, does not raise `cfg_err` and does not set `busy`.
- R8: `act_out` equals `act_in` when `row_en[act_idx]` is 1 and is 0 otherwise.
- R9: `prev_conv_en` always equals `row_en`.
- R10: `w_valid` has no effect while `busy` is 0, and `cfg_start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start | input | 1 | Start pulse: latch configuration and begin a scan or a bypass |
| cfg_fc | input | 1 | 1 = fully connected layer (scan), 0 = bypass |
| cfg_rows | input | RCNT_W | Number of input rows (1..MAX_ROWS) |
| cfg_cols | input | CCNT_W | Number of output columns (1..MAX_COLS) |
| cfg_pct | input | 6 | Threshold percentage code |
| w_valid | input | 1 | Weight beat valid |
| w_row | input | ROW_W | Row index of the beat |
| w_col | input | COL_W | Column index of the beat |
| w_data | input | WGT_W | Weight value |
| act_idx | input | ROW_W | Row whose driver input is being presented |
| act_in | input | ACT_W | Activation value for that row |
| act_out | output | ACT_W | Gated activation to the row driver |
| row_en | output | MAX_ROWS | Row driver enable mask |
| prev_conv_en | output | MAX_ROWS | Enable mask for the previous layer's output converters |
| skip_count | output | RCNT_W | Number of eliminated rows |
| busy | output | 1 | Scan in progress |
| cfg_err | output | 1 | Last start was rejected |
| seq_err | output | 1 | Last scan was aborted by an out-of-order beat |

## Verification
The bench aims at the threshold edge. A row whose zero count equals the threshold must stay enabled, and one zero more must disable it. A design using greater-or-equal, or rounding the percentage up, would clear the wrong rows. It covers the single-row, single-column matrix and an all-zero row. A design that updates the mask per row instead of at the end shows up in the mid-scan check. A stray start pulse during a scan would corrupt the mask. Idle beats that advanced the index pointer would push the next scan into a sequence error. Rejected percentage codes just outside the legal set, and a skipped index, must leave the old mask in place.

// File: rtl/rs_pkg.sv
// Shared definitions for the row skip controller.
// Assumes: percentage code is an unsigned 6-bit value.
package rs_pkg;
    localparam int PCT_W    = 6;
    localparam int PCT_MIN  = 10;
    localparam int PCT_MAX  = 40;
    localparam int PCT_STEP = 5;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_SCAN = 1'b1
    } rs_state_e;
endpackage

// File: rtl/rs_thresh.sv
// Threshold calculator: turns a percentage code and a column count into
// the largest zero count a row may have and still be kept.
// Assumes: purely combinational; the caller registers the result.
module rs_thresh
    import rs_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [PCT_W-1:0] pct,
    input  logic [CNT_W-1:0] cols,
    output logic [CNT_W-1:0] thr,
    output logic             pct_ok
);
    localparam int PROD_W = PCT_W + CNT_W;

    logic [PROD_W-1:0] prod;

    // floor(pct * cols / 100) and legality of the code
    always_comb begin
        prod   = PROD_W'(pct) * PROD_W'(cols);
        thr    = CNT_W'(prod / PROD_W'(100));
        pct_ok = (pct >= PCT_W'(PCT_MIN)) && (pct <= PCT_W'(PCT_MAX)) &&
                 ((pct % PCT_W'(PCT_STEP)) == '0);
    end
endmodule

// File: rtl/rs_scan.sv
// Stream tracker: checks the row-major index order of weight beats and
// counts zero weights inside the current row.
// Assumes: start clears the pointers; active is high only during a scan.
module rs_scan #(
    parameter int MAX_ROWS = 1024,
    parameter int MAX_COLS = 1024,
    parameter int WGT_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic                               active,
    input  logic [$clog2(MAX_ROWS+1)-1:0]      rows,
    input  logic [$clog2(MAX_COLS+1)-1:0]      cols,
    input  logic                               w_valid,
    input  logic [$clog2(MAX_ROWS)-1:0]        w_row,
    input  logic [$clog2(MAX_COLS)-1:0]        w_col,
    input  logic [WGT_W-1:0]                   w_data,
    output logic                               seq_bad,
    output logic                               row_done,
    output logic                               last_beat,
    output logic [$clog2(MAX_COLS+1)-1:0]      row_zeros,
    output logic [$clog2(MAX_ROWS)-1:0]        cur_row
);
    localparam int ROW_W  = $clog2(MAX_ROWS);
    localparam int COL_W  = $clog2(MAX_COLS);
    localparam int RCNT_W = $clog2(MAX_ROWS + 1);
    localparam int CCNT_W = $clog2(MAX_COLS + 1);

    logic [ROW_W-1:0]  exp_row;
    logic [COL_W-1:0]  exp_col;
    logic [CCNT_W-1:0] zcnt;
    logic              beat, beat_ok, end_col;

    // decode the current beat against the expected position
    always_comb begin
        beat      = active && w_valid;
        beat_ok   = beat && (w_row == exp_row) && (w_col == exp_col);
        seq_bad   = beat && !beat_ok;
        end_col   = (CCNT_W'(exp_col) == cols - CCNT_W'(1));
        row_zeros = zcnt + CCNT_W'(w_data == '0);
        row_done  = beat_ok && end_col;
        last_beat = row_done && (RCNT_W'(exp_row) == rows - RCNT_W'(1));
        cur_row   = exp_row;
    end

    // advance the expected position and the per-row zero count
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            exp_row <= '0;
            exp_col <= '0;
            zcnt    <= '0;
        end else if (beat_ok) begin
            if (end_col) begin
                exp_col <= '0;
                zcnt    <= '0;
                exp_row <= exp_row + ROW_W'(1);
            end else begin
                exp_col <= exp_col + COL_W'(1);
                zcnt    <= row_zeros;
            end
        end
    end

    // R2
    zcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt <= CCNT_W'(exp_col));
endmodule

// File: rtl/row_skip_ctrl.sv
// Row skip controller: builds a per-row enable mask for a fully connected
// layer from zero-weight counts, gates row driver inputs with it and
// exports it to the previous layer's converters.
// Assumes: MAX_ROWS and MAX_COLS are powers of two, at least 2.
module row_skip_ctrl
    import rs_pkg::*;
#(
    parameter int MAX_ROWS = 1024,
    parameter int MAX_COLS = 1024,
    parameter int WGT_W    = 8,
    parameter int ACT_W    = 8,
    localparam int ROW_W   = $clog2(MAX_ROWS),
    localparam int COL_W   = $clog2(MAX_COLS),
    localparam int RCNT_W  = $clog2(MAX_ROWS + 1),
    localparam int CCNT_W  = $clog2(MAX_COLS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_start,
    input  logic                cfg_fc,
    input  logic [RCNT_W-1:0]   cfg_rows,
    input  logic [CCNT_W-1:0]   cfg_cols,
    input  logic [PCT_W-1:0]    cfg_pct,
    input  logic                w_valid,
    input  logic [ROW_W-1:0]    w_row,
    input  logic [COL_W-1:0]    w_col,
    input  logic [WGT_W-1:0]    w_data,
    input  logic [ROW_W-1:0]    act_idx,
    input  logic [ACT_W-1:0]    act_in,
    output logic [ACT_W-1:0]    act_out,
    output logic [MAX_ROWS-1:0] row_en,
    output logic [MAX_ROWS-1:0] prev_conv_en,
    output logic [RCNT_W-1:0]   skip_count,
    output logic                busy,
    output logic                cfg_err,
    output logic                seq_err
);
    rs_state_e          state;
    logic [RCNT_W-1:0]  rows_q;
    logic [CCNT_W-1:0]  cols_q;
    logic [CCNT_W-1:0]  thr_q, thr_c;
    logic               pct_ok, size_ok, take;
    logic [MAX_ROWS-1:0] shadow, shadow_nx;
    logic [RCNT_W-1:0]  cnt_sh, cnt_nx;
    logic               seq_bad, row_done, last_beat, skip_row;
    logic [CCNT_W-1:0]  row_zeros;
    logic [ROW_W-1:0]   cur_row;

    rs_thresh #(.CNT_W(CCNT_W)) i_thresh (
        .pct    (cfg_pct),
        .cols   (cfg_cols),
        .thr    (thr_c),
        .pct_ok (pct_ok)
    );

    rs_scan #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS), .WGT_W(WGT_W)) i_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take),
        .active    (busy),
        .rows      (rows_q),
        .cols      (cols_q),
        .w_valid   (w_valid),
        .w_row     (w_row),
        .w_col     (w_col),
        .w_data    (w_data),
        .seq_bad   (seq_bad),
        .row_done  (row_done),
        .last_beat (last_beat),
        .row_zeros (row_zeros),
        .cur_row   (cur_row)
    );

    // start acceptance, size legality and per-row skip decision
    always_comb begin
        busy     = (state == RS_SCAN);
        take     = cfg_start && !busy;
        size_ok  = (cfg_rows != '0) && (cfg_rows <= RCNT_W'(MAX_ROWS)) &&
                   (cfg_cols != '0) && (cfg_cols <= CCNT_W'(MAX_COLS));
        skip_row = row_done && (row_zeros > thr_q);
        cnt_nx   = cnt_sh + RCNT_W'(skip_row);
    end

    // next shadow mask: clear only the bit of the row just finished
    for (genvar r = 0; r < MAX_ROWS; r++) begin : g_shadow
        assign shadow_nx[r] = shadow[r] & ~(skip_row && (cur_row == ROW_W'(r)));
    end

    // scan control, shadow accumulation and commit of the mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RS_IDLE;
            row_en     <= '1;
            skip_count <= '0;
            cfg_err    <= 1'b0;
            seq_err    <= 1'b0;
            shadow     <= '1;
            cnt_sh     <= '0;
            rows_q     <= '0;
            cols_q     <= '0;
            thr_q      <= '0;
        end else if (take) begin
            cfg_err <= 1'b0;
            seq_err <= 1'b0;
            if (!cfg_fc) begin
                row_en     <= '1;
                skip_count <= '0;
            end else if (!(pct_ok && size_ok)) begin
                cfg_err <= 1'b1;
            end else begin
                state  <= RS_SCAN;
                rows_q <= cfg_rows;
                cols_q <= cfg_cols;
                thr_q  <= thr_c;
                shadow <= '1;
                cnt_sh <= '0;
            end
        end else if (busy) begin
            if (seq_bad) begin
                state   <= RS_IDLE;
                seq_err <= 1'b1;
            end else if (last_beat) begin
                state      <= RS_IDLE;
                row_en     <= shadow_nx;
                skip_count <= cnt_nx;
            end else if (row_done) begin
                shadow <= shadow_nx;
                cnt_sh <= cnt_nx;
            end
        end
    end

    // gate the driver input and export the mask upstream
    always_comb begin
        act_out      = row_en[act_idx] ? act_in : '0;
        prev_conv_en = row_en;
    end

    // R3
    bad_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start && !busy && cfg_fc && !pct_ok |=> cfg_err && !busy);

    // R4
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last_beat |=> $stable(row_en));

    // R5
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_count == RCNT_W'(MAX_ROWS - $countones(row_en)));

    // R6
    seq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_bad |=> seq_err && !busy && $stable(row_en));

    // R7
    bypass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start && !busy && !cfg_fc |=> (&row_en) && !busy && !cfg_err);
endmodule

// File: tb/test_row_skip_ctrl.sv
// Self-checking bench: a vector table of matrices walked by one loop,
// then directed tests for reset, rejection, ordering and bypass.
module test_row_skip_ctrl;
    localparam int NR = 8;
    localparam int NC = 16;
    localparam int WW = 4;
    localparam int AW = 8;
    localparam int RW = $clog2(NR);
    localparam int CW = $clog2(NC);
    localparam int RCW = $clog2(NR + 1);
    localparam int CCW = $clog2(NC + 1);

    // {rows[3:0], cols[4:0], pct[5:0], zero counts row7..row0 (5 bits each)}
    localparam int NV = 5;
    localparam logic [54:0] VEC [NV] = '{
        {4'd4, 5'd10, 6'd20, 5'd0, 5'd0, 5'd0, 5'd0, 5'd10, 5'd3, 5'd2, 5'd0},
        {4'd8, 5'd7,  6'd15, 5'd0, 5'd5, 5'd1, 5'd1, 5'd7,  5'd0, 5'd2, 5'd1},
        {4'd3, 5'd16, 6'd40, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,  5'd16, 5'd7, 5'd6},
        {4'd1, 5'd1,  6'd10, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,  5'd0, 5'd0, 5'd1},
        {4'd5, 5'd13, 6'd35, 5'd0, 5'd0, 5'd0, 5'd4, 5'd0,  5'd13, 5'd5, 5'd4}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_start = 1'b0, cfg_fc = 1'b1;
    logic [RCW-1:0] cfg_rows = '0;
    logic [CCW-1:0] cfg_cols = '0;
    logic [5:0]     cfg_pct = '0;
    logic           w_valid = 1'b0;
    logic [RW-1:0]  w_row = '0;
    logic [CW-1:0]  w_col = '0;
    logic [WW-1:0]  w_data = '0;
    logic [RW-1:0]  act_idx = '0;
    logic [AW-1:0]  act_in = '0;
    logic [AW-1:0]  act_out;
    logic [NR-1:0]  row_en, prev_conv_en;
    logic [RCW-1:0] skip_count;
    logic           busy, cfg_err, seq_err;

    int n_chk = 0, n_fail = 0;
    logic [NR-1:0] cur_mask = '1;
    int cur_cnt = 0;

    always #2 clk = ~clk;

    row_skip_ctrl #(.MAX_ROWS(NR), .MAX_COLS(NC), .WGT_W(WW), .ACT_W(AW)) i_row_skip_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_fc(cfg_fc),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_pct(cfg_pct),
        .w_valid(w_valid), .w_row(w_row), .w_col(w_col), .w_data(w_data),
        .act_idx(act_idx), .act_in(act_in), .act_out(act_out),
        .row_en(row_en), .prev_conv_en(prev_conv_en), .skip_count(skip_count),
        .busy(busy), .cfg_err(cfg_err), .seq_err(seq_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input bit fc, input int rows, input int cols, input int pct);
        cfg_fc    = fc;
        cfg_rows  = RCW'(rows);
        cfg_cols  = CCW'(cols);
        cfg_pct   = 6'(pct);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    // full scan with expected mask computed from the threshold rule
    task automatic run_scan(input int rows, input int cols, input int pct,
                            input logic [39:0] zs, input bit poke);
        int thr;
        logic [NR-1:0] exp_m;
        int exp_c;
        thr   = pct * cols / 100;
        exp_m = '1;
        exp_c = 0;
        for (int r = 0; r < rows; r++) begin
            if (int'(zs[r*5 +: 5]) > thr) begin
                exp_m[r] = 1'b0;
                exp_c++;
            end
        end
        pulse_start(1'b1, rows, cols, pct);
        chk("R4 busy after start", 64'(busy), 64'd1);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                w_valid = 1'b1;
                w_row   = RW'(r);
                w_col   = CW'(c);
                w_data  = (c < int'(zs[r*5 +: 5])) ? '0 : WW'((c % 15) + 1);
                if (poke && r == 0 && c == 0) begin
                    cfg_fc    = 1'b0;
                    cfg_start = 1'b1;
                end else begin
                    cfg_start = 1'b0;
                    cfg_fc    = 1'b1;
                end
                @(negedge clk);
                if (r == 0 && c == cols - 1 && rows > 1) begin
                    chk("R4 old mask held mid-scan", 64'(row_en), 64'(cur_mask));
                    chk("R4 busy mid-scan", 64'(busy), 64'd1);
                end
            end
        end
        w_valid   = 1'b0;
        cfg_start = 1'b0;
        cfg_fc    = 1'b1;
        chk("R2 mask", 64'(row_en), 64'(exp_m));
        chk("R5 skip count", 64'(skip_count), 64'(exp_c));
        chk("R9 exported mask", 64'(prev_conv_en), 64'(exp_m));
        chk("R4 busy cleared", 64'(busy), 64'd0);
        chk("R6 no seq error", 64'(seq_err), 64'd0);
        cur_mask = exp_m;
        cur_cnt  = exp_c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mask", 64'(row_en), 64'hFF);
        chk("R1 count", 64'(skip_count), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 errors", 64'({cfg_err, seq_err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_scan(int'(VEC[v][54:51]), int'(VEC[v][50:46]), int'(VEC[v][45:40]),
                     VEC[v][39:0], 1'b0);
        end

        // R8 gating with the last mask (rows 1 and 2 skipped)
        act_in  = 8'hA5;
        act_idx = 3'd1;
        #1;
        chk("R8 skipped row gets zero", 64'(act_out), 64'd0);
        act_idx = 3'd0;
        #1;
        chk("R8 enabled row passes", 64'(act_out), 64'hA5);
        @(negedge clk);

        // R3 rejected codes and sizes
        pulse_start(1'b1, 4, 10, 12);
        chk("R3 pct 12 flagged", 64'(cfg_err), 64'd1);
        chk("R3 no busy", 64'(busy), 64'd0);
        pulse_start(1'b1, 4, 10, 45);
        chk("R3 pct 45 flagged", 64'(cfg_err), 64'd1);
        pulse_start(1'b1, 4, 10, 5);
        chk("R3 pct 5 flagged", 64'(cfg_err), 64'd1);
        pulse_start(1'b1, 4, 0, 20);
        chk("R3 zero cols flagged", 64'(cfg_err), 64'd1);
        chk("R3 mask unchanged", 64'(row_en), 64'(cur_mask));

        // R10 idle beats have no effect
        w_valid = 1'b1; w_row = '0; w_col = '0; w_data = '0;
        repeat (3) @(negedge clk);
        w_valid = 1'b0;
        chk("R10 idle beats mask", 64'(row_en), 64'(cur_mask));
        chk("R10 idle beats count", 64'(skip_count), 64'(cur_cnt));
        // R10 start while busy ignored; scan still completes correctly
        run_scan(4, 10, 20, {5'd0, 5'd0, 5'd0, 5'd0, 5'd3, 5'd2, 5'd10, 5'd1}, 1'b1);
        chk("R3 cfg_err cleared by good start", 64'(cfg_err), 64'd0);

        // R6 out-of-order beat
        pulse_start(1'b1, 2, 4, 25);
        w_valid = 1'b1; w_row = '0; w_col = CW'(0); w_data = '0;
        @(negedge clk);
        w_col = CW'(2);
        @(negedge clk);
        w_valid = 1'b0;
        chk("R6 seq_err set", 64'(seq_err), 64'd1);
        chk("R6 scan aborted", 64'(busy), 64'd0);
        chk("R6 mask unchanged", 64'(row_en), 64'(cur_mask));

        // R7 bypass with an illegal code still enables all rows
        pulse_start(1'b0, 0, 0, 3);
        chk("R7 all rows on", 64'(row_en), 64'hFF);
        chk("R7 count zero", 64'(skip_count), 64'd0);
        chk("R7 no cfg_err", 64'(cfg_err), 64'd0);
        chk("R7 no busy", 64'(busy), 64'd0);
        chk("R9 exported in bypass", 64'(prev_conv_en), 64'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule